// File: doc/BRIEF.md
# Unified Dual-Port Word Memory

This block is a word-organised memory that feeds a pipelined core through two independent ports: a fetch port that only reads, and a data port that reads or writes. Both ports look into one shared array of 32-bit words, so a word written through the data port is the same word the fetch port later returns. Reads on either port are purely combinational: the word appears in the same cycle as the request. A store is committed at the rising clock edge that ends the cycle in which it was requested.

Addresses are byte addresses, but the memory only knows whole words. The two lowest address bits are discarded, and the bits above the parameterised depth are discarded as well, so the address space wraps around the array. A small 8-bit host mailbox register sits beside the array. The core writes it, a reset clears it, and a nonzero value tells the surrounding environment that the running program has finished.

The idle-read behaviour is a parameter: by default a port whose valid is low drives zeros on its read bus. A second variant passes the raw array word through instead.

Top module: `umem_top`

## Requirements
- R1: On both ports, byte address bits [1:0] do not take part in word selection; addresses differing only in those bits reach the same word.
- R2: Both ports share one storage array; a word stored through the data port is returned by the fetch port from the next cycle on.
- R3: Read data on both ports follows the request address combinationally, within the same cycle, with no clock edge in between.
- R4: A store happens only when data_valid is 1 and data_write is 1 (data_write: 0 = load, 1 = store); with either of them at 0 the array is left unchanged.
- R5: A read of a word in the same cycle as a store to that word returns the old contents; the new contents are returned after the edge.
- R6: With the default ZERO_IDLE = 1, a port whose valid is 0 drives all zeros on its read data bus.
- R7: The array holds DEPTH_WORDS words (a power of two, default 256); address bits above the word index are ignored, so byte address A and A + 4*DEPTH_WORDS reach the same word.
- R8: host_value is 0 after reset, takes host_wdata at a clock edge where host_we is 1, and holds its value at every other edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; stores and host writes commit on its rising edge |
| rst | input | 1 | Synchronous active-high reset of the host mailbox |
| fetch_valid | input | 1 | Fetch port request strobe |
| fetch_addr | input | 32 | Fetch port byte address |
| fetch_rdata | output | 32 | Fetch port word, combinational |
| data_valid | input | 1 | Data port request strobe |
| data_write | input | 1 | Data port direction, 0 load, 1 store |
| data_addr | input | 32 | Data port byte address |
| data_wdata | input | 32 | Store data bus |
| data_rdata | output | 32 | Load data bus, combinational |
| host_we | input | 1 | Host mailbox write strobe |
| host_wdata | input | 8 | Host mailbox write value |
| host_value | output | 8 | Host mailbox contents |

## Verification
The hardest situation to reach is a same-cycle collision: a store and a read of the same word in one cycle, where the read must still show the old word and the new word must only appear after the edge. The bench holds a store on the data port while pointing the fetch port at an aliased address of the same word (different low bits and a wrapped upper part), samples both read buses before the edge, and samples again after it. Stores with valid low or with the direction bit low are issued against words of known contents and read back through the fetch port to show nothing changed.

// File: rtl/umem_pkg.sv
package umem_pkg;

   // Width of the byte offset inside one 32-bit word.
   localparam int unsigned BYTE_OFS_W = 2;

   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

   function automatic int unsigned index_width(input int unsigned depth);
      return (depth < 2) ? 1 : $clog2(depth);
   endfunction

endpackage

// File: rtl/umem_word_index.sv
module umem_word_index #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned IDX_W  = 8
) (
   input  logic [ADDR_W-1:0] byte_addr,
   output logic [IDX_W-1:0]  word_idx
);
   import umem_pkg::*;

   localparam int unsigned TOP_BIT = IDX_W + BYTE_OFS_W;

   initial begin
      assert (TOP_BIT <= ADDR_W)
         else $error("umem_word_index: index does not fit the address");
   end

   assign word_idx = byte_addr[TOP_BIT-1:BYTE_OFS_W];

   // Discarded bits: the byte offset, and anything above the array depth.
   generate
      if (TOP_BIT < ADDR_W) begin : g_wrap
         logic unused_bits;
         assign unused_bits = ^{byte_addr[ADDR_W-1:TOP_BIT], byte_addr[BYTE_OFS_W-1:0]};
      end else begin : g_full
         logic unused_bits;
         assign unused_bits = ^byte_addr[BYTE_OFS_W-1:0];
      end
   endgenerate

endmodule

// File: rtl/umem_store.sv
module umem_store #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned DEPTH  = 256,
   parameter int unsigned IDX_W  = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [IDX_W-1:0]  rd_idx_a,
   output logic [DATA_W-1:0] rd_data_a,
   input  logic [IDX_W-1:0]  rd_idx_b,
   output logic [DATA_W-1:0] rd_data_b
);

   logic [DATA_W-1:0] mem [DEPTH];

   initial begin
      assert ((1 << IDX_W) == DEPTH)
         else $error("umem_store: IDX_W must address DEPTH exactly");
   end

   always_ff @(posedge clk) begin
      if (wr_en) begin
         mem[wr_idx] <= wr_data;
      end
   end

   // Combinational reads see the contents before the pending edge.
   assign rd_data_a = mem[rd_idx_a];
   assign rd_data_b = mem[rd_idx_b];

   // R4: a requested store has landed at the word it named.
   p_store_lands_r4 : assert property (@(posedge clk) disable iff (rst)
      wr_en |=> (mem[$past(wr_idx)] == $past(wr_data)));

   // R4: without a store the word under port b keeps its contents.
   p_no_store_r4 : assert property (@(posedge clk) disable iff (rst)
      !wr_en |=> (mem[$past(rd_idx_b)] == $past(rd_data_b)));

endmodule

// File: rtl/umem_read_gate.sv
module umem_read_gate #(
   parameter int unsigned DATA_W    = 32,
   parameter bit          ZERO_IDLE = 1'b1
) (
   input  logic              req_valid,
   input  logic [DATA_W-1:0] raw_data,
   output logic [DATA_W-1:0] port_data
);

   generate
      if (ZERO_IDLE) begin : g_zero
         assign port_data = req_valid ? raw_data : '0;
      end else begin : g_pass
         logic unused_valid;
         assign unused_valid = req_valid;
         assign port_data    = raw_data;
      end
   endgenerate

endmodule

// File: rtl/umem_host_reg.sv
module umem_host_reg #(
   parameter int unsigned HOST_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load,
   input  logic [HOST_W-1:0] load_val,
   output logic [HOST_W-1:0] value
);

   always_ff @(posedge clk) begin
      if (rst) begin
         value <= '0;
      end else if (load) begin
         value <= load_val;
      end
   end

   // R8: the mailbox only changes when written.
   p_host_hold_r8 : assert property (@(posedge clk) disable iff (rst)
      !load |=> $stable(value));

   // R8: a write is taken at the edge.
   p_host_load_r8 : assert property (@(posedge clk) disable iff (rst)
      load |=> (value == $past(load_val)));

endmodule

// File: rtl/umem_top.sv
module umem_top #(
   parameter int unsigned ADDR_W      = 32,
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned DEPTH_WORDS = 256,
   parameter int unsigned HOST_W      = 8,
   parameter bit          ZERO_IDLE   = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              fetch_valid,
   input  logic [ADDR_W-1:0] fetch_addr,
   output logic [DATA_W-1:0] fetch_rdata,
   input  logic              data_valid,
   input  logic              data_write,
   input  logic [ADDR_W-1:0] data_addr,
   input  logic [DATA_W-1:0] data_wdata,
   output logic [DATA_W-1:0] data_rdata,
   input  logic              host_we,
   input  logic [HOST_W-1:0] host_wdata,
   output logic [HOST_W-1:0] host_value
);
   import umem_pkg::*;

   localparam int unsigned IDX_W = index_width(DEPTH_WORDS);

   initial begin
      assert (is_pow2(DEPTH_WORDS) && DEPTH_WORDS >= 2)
         else $error("umem_top: DEPTH_WORDS must be a power of two, at least 2");
      assert (DATA_W == 32)
         else $error("umem_top: words are 32 bits wide");
      assert (HOST_W >= 1 && HOST_W <= DATA_W)
         else $error("umem_top: HOST_W out of range");
   end

   logic [IDX_W-1:0]  fetch_idx;
   logic [IDX_W-1:0]  data_idx;
   logic [DATA_W-1:0] fetch_raw;
   logic [DATA_W-1:0] data_raw;
   logic              store_en;

   assign store_en = data_valid & data_write;

   umem_word_index #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_fetch_idx (
      .byte_addr (fetch_addr),
      .word_idx  (fetch_idx)
   );

   umem_word_index #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_data_idx (
      .byte_addr (data_addr),
      .word_idx  (data_idx)
   );

   umem_store #(.DATA_W(DATA_W), .DEPTH(DEPTH_WORDS), .IDX_W(IDX_W)) u_store (
      .clk       (clk),
      .rst       (rst),
      .wr_en     (store_en),
      .wr_idx    (data_idx),
      .wr_data   (data_wdata),
      .rd_idx_a  (fetch_idx),
      .rd_data_a (fetch_raw),
      .rd_idx_b  (data_idx),
      .rd_data_b (data_raw)
   );

   umem_read_gate #(.DATA_W(DATA_W), .ZERO_IDLE(ZERO_IDLE)) u_fetch_gate (
      .req_valid (fetch_valid),
      .raw_data  (fetch_raw),
      .port_data (fetch_rdata)
   );

   umem_read_gate #(.DATA_W(DATA_W), .ZERO_IDLE(ZERO_IDLE)) u_data_gate (
      .req_valid (data_valid),
      .raw_data  (data_raw),
      .port_data (data_rdata)
   );

   umem_host_reg #(.HOST_W(HOST_W)) u_host (
      .clk      (clk),
      .rst      (rst),
      .load     (host_we),
      .load_val (host_wdata),
      .value    (host_value)
   );

   // R2 / R7: both ports naming one word see one value.
   p_ports_agree_r2 : assert property (@(posedge clk) disable iff (rst)
      (fetch_valid && data_valid &&
       fetch_addr[IDX_W+1:2] == data_addr[IDX_W+1:2]) |-> (fetch_rdata == data_rdata));

   // R5: a fetch of the word being stored still shows the previous word.
   p_old_on_collide_r5 : assert property (@(posedge clk) disable iff (rst)
      (store_en && fetch_valid && fetch_idx == data_idx) |-> (fetch_rdata == data_raw));

   generate
      if (ZERO_IDLE) begin : g_idle_chk
         // R6: idle ports drive zeros.
         p_idle_zero_r6 : assert property (@(posedge clk) disable iff (rst)
            (!fetch_valid |-> fetch_rdata == '0) and (!data_valid |-> data_rdata == '0));
      end
   endgenerate

endmodule

// File: tb/sim_umem_top.sv
module sim_umem_top;

   localparam int CLK_PERIOD = 10;
   localparam int DEPTH      = 256;
   localparam int WRAP       = DEPTH * 4;
   localparam int NVEC       = 8;

   // Each vector: store byte address, store word, fetch byte address (alias).
   localparam logic [95:0] VEC [NVEC] = '{
      {32'h0000_0000, 32'h1111_2222, 32'h0000_0003},
      {32'h0000_0004, 32'hDEAD_BEEF, 32'h0000_0405},
      {32'h0000_0010, 32'h0000_0001, 32'h0000_0012},
      {32'h0000_03FC, 32'hFFFF_FFFF, 32'h0000_07FF},
      {32'h0000_0100, 32'hA5A5_5A5A, 32'hFFFF_F101},
      {32'h0000_0200, 32'h8000_0000, 32'h1234_5600},
      {32'h0000_0044, 32'h0F0F_F0F0, 32'h0000_0846},
      {32'h0000_0088, 32'h7654_3210, 32'h0000_0C8B}
   };

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        fetch_valid = 1'b0;
   logic [31:0] fetch_addr  = '0;
   logic [31:0] fetch_rdata;
   logic        data_valid = 1'b0;
   logic        data_write = 1'b0;
   logic [31:0] data_addr  = '0;
   logic [31:0] data_wdata = '0;
   logic [31:0] data_rdata;
   logic        host_we = 1'b0;
   logic [7:0]  host_wdata = '0;
   logic [7:0]  host_value;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   umem_top u0 (
      .clk(clk), .rst(rst),
      .fetch_valid(fetch_valid), .fetch_addr(fetch_addr), .fetch_rdata(fetch_rdata),
      .data_valid(data_valid), .data_write(data_write), .data_addr(data_addr),
      .data_wdata(data_wdata), .data_rdata(data_rdata),
      .host_we(host_we), .host_wdata(host_wdata), .host_value(host_value)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   // Drive in the low phase, let the edge commit, return to the low phase.
   task automatic store(input logic [31:0] a, input logic [31:0] d,
                        input logic v, input logic w);
      @(negedge clk);
      data_valid = v; data_write = w; data_addr = a; data_wdata = d;
      @(negedge clk);
      data_valid = 1'b0; data_write = 1'b0;
   endtask

   task automatic fetch_word(input logic [31:0] a, output logic [31:0] d);
      fetch_valid = 1'b1; fetch_addr = a;
      #1 d = fetch_rdata;
      fetch_valid = 1'b0;
   endtask

   initial begin
      logic [31:0] got;
      repeat (3) @(negedge clk);
      check("R8 reset value", {24'h0, host_value}, 32'h0);
      rst = 1'b0;

      // Table walk: store, then read back through the fetch port at an alias.
      for (int i = 0; i < NVEC; i++) begin
         store(VEC[i][95:64], VEC[i][63:32], 1'b1, 1'b1);
         fetch_word(VEC[i][31:0], got);
         check("R1 R2 R7 alias fetch", got, VEC[i][63:32]);
      end

      // R3: data-port load is combinational, follows the address change.
      data_valid = 1'b1; data_addr = 32'h0000_0004;
      #1 check("R3 load same cycle", data_rdata, 32'hDEAD_BEEF);
      data_addr = 32'h0000_0011;
      #1 check("R3 load follows addr", data_rdata, 32'h0000_0001);
      data_valid = 1'b0;

      // R6: idle ports read zero.
      fetch_addr = 32'h0000_0004; data_addr = 32'h0000_0004;
      #1 check("R6 idle fetch", fetch_rdata, 32'h0);
      check("R6 idle data", data_rdata, 32'h0);

      // R4: gated-off stores leave the word alone.
      store(32'h0000_0004, 32'h0BAD_0BAD, 1'b0, 1'b1);
      fetch_word(32'h0000_0004, got);
      check("R4 valid low no store", got, 32'hDEAD_BEEF);
      store(32'h0000_0004, 32'h0BAD_0BAD, 1'b1, 1'b0);
      fetch_word(32'h0000_0004, got);
      check("R4 load no store", got, 32'hDEAD_BEEF);

      // R5: collision of store and fetch on one word.
      @(negedge clk);
      data_valid = 1'b1; data_write = 1'b1;
      data_addr = 32'h0000_0010; data_wdata = 32'hCAFE_F00D;
      fetch_valid = 1'b1; fetch_addr = 32'h0000_0010 + WRAP + 3;
      #1 check("R5 fetch old before edge", fetch_rdata, 32'h0000_0001);
      check("R5 data old before edge", data_rdata, 32'h0000_0001);
      @(negedge clk);
      data_valid = 1'b0; data_write = 1'b0;
      #1 check("R5 fetch new after edge", fetch_rdata, 32'hCAFE_F00D);
      fetch_valid = 1'b0;

      // R8: host mailbox load and hold.
      @(negedge clk);
      host_we = 1'b1; host_wdata = 8'h5A;
      @(negedge clk);
      host_we = 1'b0; host_wdata = 8'hC3;
      check("R8 host load", {24'h0, host_value}, 32'h5A);
      @(negedge clk);
      check("R8 host hold", {24'h0, host_value}, 32'h5A);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      check("R8 host cleared by reset", {24'h0, host_value}, 32'h0);

      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            n_tests++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
         end
      join_any
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule